// File: doc/BRIEF.md
# Armed Threshold Comparator with Concealed Hysteresis

This block turns a stream of digitised field samples into a single output decision. Each sample that arrives with its valid strobe is compared against a programmable switching level. The result drives the gate of an open-drain output stage. In its default mode the output has no observable hysteresis. It switches exactly when the sample crosses the switching level, but only while an internal arming flag is set. Two guard levels, placed one guard offset above and one below the switching level, decide when the flag is set again after a switch. A mode input selects the alternative, visible scheme: the rising decision uses the upper guard level, the falling decision uses the lower guard level, and there is no arming. An invert input swaps the output polarity. A hold input freezes what the pin shows while the decision logic keeps tracking the samples.

Every transition of the output produces a one-cycle event pulse for downstream counters. Transitions towards the high-field state and towards the low-field state are also flagged on separate lines.

Top module: `armed_hyst_cmp`

## Requirements
- R1: After reset the internal field state is low, the arming flag is set, the pin is released (`outPullDown` = 0) when `invertOut` = 0, and all event outputs are 0.
- R2: With `invertOut` = 0, a high field state drives `outPullDown` = 1 and a low field state drives 0. With `invertOut` = 1 the mapping is swapped.
- R3: In concealed mode, an armed low state switches high on a valid sample strictly greater than `switchLevel`. A sample equal to the level causes no switch. An armed high state switches low on a sample strictly below the level.
- R4: In concealed mode, every switch clears the arming flag. While it is clear, samples that cross `switchLevel` without passing a guard level cause no switch.
- R5: After a rising switch, a valid sample above `switchLevel + guardOffset` sets the arming flag. A later sample below `switchLevel` then switches the output low.
- R6: After a rising switch, a valid sample below `switchLevel - guardOffset` sets the arming flag, so the next valid sample below the level switches low. The same holds mirrored after a falling switch. The switch comes one sample after the guard crossing.
- R7: In visible mode, the low state switches high only on a sample strictly greater than `switchLevel + guardOffset`. The high state switches low only on a sample strictly below `switchLevel - guardOffset`.
- R8: While `holdOut` = 1 the pin state and the event outputs do not change, but the field state keeps tracking. In the cycle after `holdOut` returns to 0, the pin takes the tracked state and an event is flagged if the pin state changes.
- R9: Each change of the displayed field state raises `switchEvent` for exactly one cycle, in the same cycle the pin changes. `eventRise` marks a low-to-high field change and `eventFall` a high-to-low field change.
- R10: A sample presented with `sampleValid` = 0 has no effect on the field state or the arming flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleIn | input | SAMPLE_W | Unsigned field sample |
| sampleValid | input | 1 | Qualifies sampleIn for one cycle |
| switchLevel | input | SAMPLE_W | Switching level, unsigned |
| guardOffset | input | GUARD_W | Distance of both guard levels from the switching level |
| visibleMode | input | 1 | 1 selects visible hysteresis, 0 selects concealed arming |
| invertOut | input | 1 | Swaps output polarity |
| holdOut | input | 1 | Freezes the pin state and events |
| outPullDown | output | 1 | Open-drain gate: 1 pulls the pin low |
| switchEvent | output | 1 | One-cycle pulse per output transition |
| eventRise | output | 1 | Pulse for a low-to-high field transition |
| eventFall | output | 1 | Pulse for a high-to-low field transition |

## Verification
The hardest case to reach is the same-side re-arm. After a rising switch, the signal has to fall back through the switching level while disarmed, and then dip under the lower guard without ever having passed the upper one. Only then may the output switch low, one sample later. The stimulus builds this directly: a level-crossing sample, then a sample just under the level that must not switch, then one under the lower guard, then one between the lower guard and the level, which must produce the fall. Hold release after internal tracking is the other awkward corner. It is reached by switching the field state while the pin is frozen.

// File: rtl/armcmp_pkg.sv
package armcmp_pkg;

  // Comparison results handed from the datapath to the control
  typedef struct packed {
    logic aboveLevel;   // sample >  switching level
    logic belowLevel;   // sample <  switching level
    logic aboveUpper;   // sample >  level + guard
    logic belowLower;   // sample <  level - guard
  } cmpStrobes_t;

  // Decisions handed from the control to the output stage
  typedef struct packed {
    logic showField;    // field state the pin should show
    logic loadPin;      // pin may follow showField this cycle
  } pinStrobes_t;

endpackage

// File: rtl/armcmp_datapath.sv
module armcmp_datapath
  import armcmp_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int GUARD_W  = 6
) (
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] switchLevel,
  input  logic [GUARD_W-1:0]  guardOffset,
  output cmpStrobes_t         cmpOut
);

  // Two extra bits keep level +/- guard free of wrap-around
  localparam int EXT_W = SAMPLE_W + 2;

  logic signed [EXT_W-1:0] sampleExt;
  logic signed [EXT_W-1:0] levelExt;
  logic signed [EXT_W-1:0] guardExt;
  logic signed [EXT_W-1:0] upperGuard;
  logic signed [EXT_W-1:0] lowerGuard;

  always_comb begin
    sampleExt  = $signed({2'b00, sampleIn});
    levelExt   = $signed({2'b00, switchLevel});
    guardExt   = $signed({{(EXT_W-GUARD_W){1'b0}}, guardOffset});
    upperGuard = levelExt + guardExt;
    lowerGuard = levelExt - guardExt;
  end

  always_comb begin
    cmpOut.aboveLevel = sampleExt > levelExt;
    cmpOut.belowLevel = sampleExt < levelExt;
    cmpOut.aboveUpper = sampleExt > upperGuard;
    cmpOut.belowLower = sampleExt < lowerGuard;
  end

endmodule

// File: rtl/armcmp_control.sv
module armcmp_control
  import armcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sampleValid,
  input  logic        visibleMode,
  input  logic        holdOut,
  input  cmpStrobes_t cmpIn,
  output pinStrobes_t pinCtl,
  output logic        fieldHigh,
  output logic        armed
);

  logic highNext;
  logic armNext;

  always_comb begin
    highNext = fieldHigh;
    armNext  = armed;
    if (sampleValid) begin
      if (visibleMode) begin
        armNext = 1'b1;
        if (!fieldHigh && cmpIn.aboveUpper)      highNext = 1'b1;
        else if (fieldHigh && cmpIn.belowLower)  highNext = 1'b0;
      end else if (armed) begin
        if (!fieldHigh && cmpIn.aboveLevel) begin
          highNext = 1'b1;
          armNext  = 1'b0;
        end else if (fieldHigh && cmpIn.belowLevel) begin
          highNext = 1'b0;
          armNext  = 1'b0;
        end
      end else if (cmpIn.aboveUpper || cmpIn.belowLower) begin
        armNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fieldHigh <= 1'b0;
      armed     <= 1'b1;
    end else begin
      fieldHigh <= highNext;
      armed     <= armNext;
    end
  end

  always_comb begin
    pinCtl.showField = highNext;
    pinCtl.loadPin   = !holdOut;
  end

  // A field change in concealed mode needs a prior arm and leaves the flag clear
  AST_SWITCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fieldHigh != $past(fieldHigh)) && !$past(visibleMode) |-> $past(armed)); // R4
  AST_DISARM_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fieldHigh != $past(fieldHigh)) && !$past(visibleMode) |-> !armed); // R4
  AST_VISIBLE_RISE_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fieldHigh) && $past(visibleMode) |-> $past(cmpIn.aboveUpper)); // R7
  AST_VISIBLE_FALL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fieldHigh) && $past(visibleMode) |-> $past(cmpIn.belowLower)); // R7
  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sampleValid) |-> $stable(fieldHigh) && $stable(armed)); // R10

endmodule

// File: rtl/armcmp_output.sv
module armcmp_output
  import armcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pinStrobes_t pinCtl,
  input  logic        invertOut,
  output logic        outPullDown,
  output logic        switchEvent,
  output logic        eventRise,
  output logic        eventFall
);

  logic shownField;
  logic changeNow;

  always_comb changeNow = pinCtl.loadPin && (pinCtl.showField != shownField);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shownField  <= 1'b0;
      switchEvent <= 1'b0;
      eventRise   <= 1'b0;
      eventFall   <= 1'b0;
    end else begin
      if (pinCtl.loadPin) shownField <= pinCtl.showField;
      switchEvent <= changeNow;
      eventRise   <= changeNow && pinCtl.showField;
      eventFall   <= changeNow && !pinCtl.showField;
    end
  end

  // Non-inverted: high field pulls the pin low
  always_comb outPullDown = invertOut ? !shownField : shownField;

  AST_EVENT_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    switchEvent |-> shownField != $past(shownField)); // R9
  AST_RISE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    eventRise |-> shownField && !eventFall); // R9
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pinCtl.loadPin) |-> $stable(shownField) && !switchEvent); // R8

endmodule

// File: rtl/armed_hyst_cmp.sv
module armed_hyst_cmp
  import armcmp_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int GUARD_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] switchLevel,
  input  logic [GUARD_W-1:0]  guardOffset,
  input  logic                visibleMode,
  input  logic                invertOut,
  input  logic                holdOut,
  output logic                outPullDown,
  output logic                switchEvent,
  output logic                eventRise,
  output logic                eventFall
);

  cmpStrobes_t cmpBus;
  pinStrobes_t pinBus;
  logic        fieldHigh;
  logic        armed;

  armcmp_datapath #(.SAMPLE_W(SAMPLE_W), .GUARD_W(GUARD_W)) uDatapath (
    .sampleIn   (sampleIn),
    .switchLevel(switchLevel),
    .guardOffset(guardOffset),
    .cmpOut     (cmpBus)
  );

  armcmp_control uControl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .visibleMode(visibleMode),
    .holdOut    (holdOut),
    .cmpIn      (cmpBus),
    .pinCtl     (pinBus),
    .fieldHigh  (fieldHigh),
    .armed      (armed)
  );

  armcmp_output uOutput (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinCtl     (pinBus),
    .invertOut  (invertOut),
    .outPullDown(outPullDown),
    .switchEvent(switchEvent),
    .eventRise  (eventRise),
    .eventFall  (eventFall)
  );

  // The pin can only show a high field after the tracked state went high
  AST_PIN_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    eventRise |-> $past(fieldHigh) || fieldHigh); // R9

endmodule

// File: tb/tb_armed_hyst_cmp.sv
`timescale 1ns/1ps
module tb_armed_hyst_cmp;

  localparam int SW = 10;
  localparam int GW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] switchLevel = 10'd500;
  logic [GW-1:0] guardOffset = 6'd8;
  logic          visibleMode = 1'b0;
  logic          invertOut = 1'b0;
  logic          holdOut = 1'b0;
  logic          outPullDown, switchEvent, eventRise, eventFall;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  armed_hyst_cmp #(.SAMPLE_W(SW), .GUARD_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .switchLevel(switchLevel), .guardOffset(guardOffset), .visibleMode(visibleMode),
    .invertOut(invertOut), .holdOut(holdOut), .outPullDown(outPullDown),
    .switchEvent(switchEvent), .eventRise(eventRise), .eventFall(eventFall)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic vis, input logic inv);
    @(negedge clk);
    visibleMode = vis; invertOut = inv; holdOut = 1'b0; sampleValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Present one valid sample; outputs are checked one negedge later
  task automatic put(input int v);
    @(negedge clk);
    sampleIn = SW'(v); sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic expectState(input string req, input logic pd, input logic ev, input logic rs, input logic fl);
    chk(req, "outPullDown", outPullDown, pd);
    chk(req, "switchEvent", switchEvent, ev);
    chk(req, "eventRise", eventRise, rs);
    chk(req, "eventFall", eventFall, fl);
  endtask

  task automatic testResetState();
    doReset(1'b0, 1'b0);
    expectState("R1", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testHiddenSwitch();
    doReset(1'b0, 1'b0);
    put(500); expectState("R3 equal level", 1'b0, 1'b0, 1'b0, 1'b0);
    put(501); expectState("R3 rise", 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); chk("R9 one cycle", "switchEvent", switchEvent, 1'b0);
    put(499); expectState("R4 disarmed", 1'b1, 1'b0, 1'b0, 1'b0);
    put(495); expectState("R4 disarmed", 1'b1, 1'b0, 1'b0, 1'b0);
    put(510); expectState("R5 upper arms", 1'b1, 1'b0, 1'b0, 1'b0);
    put(499); expectState("R5 fall", 1'b0, 1'b1, 1'b0, 1'b1);
    put(501); expectState("R4 no rise unarmed", 1'b0, 1'b0, 1'b0, 1'b0);
    put(490); expectState("R6 low guard arms", 1'b0, 1'b0, 1'b0, 1'b0);
    put(501); expectState("R3 rise after arm", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testSameSideRearm();
    doReset(1'b0, 1'b0);
    put(505); expectState("R6 rise", 1'b1, 1'b1, 1'b1, 1'b0);
    put(498); expectState("R6 no fall", 1'b1, 1'b0, 1'b0, 1'b0);
    put(491); expectState("R6 arm only", 1'b1, 1'b0, 1'b0, 1'b0);
    put(495); expectState("R6 fall", 1'b0, 1'b1, 1'b0, 1'b1);
    put(509); expectState("R6 mirrored arm", 1'b0, 1'b0, 1'b0, 1'b0);
    put(502); expectState("R6 mirrored rise", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testInvalidIgnored();
    doReset(1'b0, 1'b0);
    @(negedge clk); sampleIn = SW'(700); sampleValid = 1'b0;
    @(negedge clk); @(negedge clk);
    expectState("R10 ignored", 1'b0, 1'b0, 1'b0, 1'b0);
    put(501); expectState("R10 still armed", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testVisible();
    doReset(1'b1, 1'b0);
    put(505); expectState("R7 inside band", 1'b0, 1'b0, 1'b0, 1'b0);
    put(508); expectState("R7 at on-level", 1'b0, 1'b0, 1'b0, 1'b0);
    put(509); expectState("R7 rise", 1'b1, 1'b1, 1'b1, 1'b0);
    put(495); expectState("R7 inside band", 1'b1, 1'b0, 1'b0, 1'b0);
    put(492); expectState("R7 at off-level", 1'b1, 1'b0, 1'b0, 1'b0);
    put(491); expectState("R7 fall", 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    doReset(1'b0, 1'b0);
    @(negedge clk); holdOut = 1'b1;
    put(501); expectState("R8 frozen", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); holdOut = 1'b0;
    @(negedge clk); expectState("R8 release", 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); holdOut = 1'b1;
    put(510); put(499); expectState("R8 frozen high", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); holdOut = 1'b0;
    @(negedge clk); expectState("R8 release fall", 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testInvert();
    doReset(1'b0, 1'b1);
    expectState("R2 inverted low field", 1'b1, 1'b0, 1'b0, 1'b0);
    put(501); expectState("R2 inverted high field", 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); invertOut = 1'b0;
    #1 chk("R2 polarity swap", "outPullDown", outPullDown, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testHiddenSwitch();
    testSameSideRearm();
    testInvalidIgnored();
    testVisible();
    testHold();
    testInvert();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule